// File: doc/BRIEF.md
# Four-Channel Ripple-Spreading Pulse Width Modulator

This block drives four pulse-width outputs from one shared 10-bit free-running period counter. The counter steps only when an external prescaler raises a one-cycle tick, so a full period is 1024 ticks long. Each channel holds a 10-bit width value `n` and a mode bit. In both modes the output is high for exactly `n+1` counts of each period.

In continuous mode the high time is one unbroken pulse at the start of the period. In spread mode the period is cut into four 256-count quadrants. Each quadrant gets a base pulse of `n>>2` counts. The two low bits of `n` add one extra count to the leading quadrants, so that after external low-pass filtering the ripple is about four times smaller. New settings are written over a simple strobe-and-select port into a pending slot. They are copied to the live slot only at the period wrap, so a period is never cut short.

Each channel is a two-state machine over its live mode (`MODE_CONT`, `MODE_SPREAD`). The transition between them is taken only at a period wrap, when the pending mode differs from the live one. A pending value that is unchanged keeps the state as it is.

Top module: `pwm_spread4`

## Requirements
- R1: The shared counter steps 0,1,...,1023 and then returns to 0 on the tick after 1023, so every period lasts 1024 ticks.
- R2: In continuous mode (mode bit 0) a channel is high while the count is at most `n`. That gives `n+1` counts starting at count 0, and with `n=1023` the output is high for the whole period.
- R3: In spread mode (mode bit 1) the quadrant `q` is count bits [9:8] and the offset is count bits [7:0]. The output is high while offset < `(n>>2) + (q <= n[1:0] ? 1 : 0)`.
- R4: In spread mode the total high time over one period equals `n+1` counts.
- R5: While `tick` is low the counter holds and the outputs do not change.
- R6: A write (`wr_en`=1) stores `wr_width` and `wr_spread` as pending for channel `wr_sel` (0 to 3) only. The other channels keep their settings.
- R7: Pending settings take effect only at the period wrap (a tick while the count is 1023) and are first used for count 0. Until then the old settings stay in force for the rest of the period.
- R8: Outputs are registered. `pwm_out` after a clock edge reflects the count and live settings that held before that edge.
- R9: Synchronous active-high `rst` clears the counter, the pending and live widths (0, continuous mode) and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter step enable from an external prescaler |
| wr_en | input | 1 | Write strobe for the pending settings |
| wr_sel | input | 2 | Channel selected by the write |
| wr_width | input | 10 | Width value `n` to store |
| wr_spread | input | 1 | Mode to store: 0 continuous, 1 spread |
| pwm_out | output | 4 | Registered channel outputs, bit c is channel c |

## Verification
The assertions check the following on every cycle:
- the counter steps, wraps and holds correctly;
- the live settings never move except at a wrap;
- every output is high in the cycle after count 0;
- a full-scale continuous width keeps its output high;
- reset forces the outputs low.

The exact high totals, the split of the high time across the quadrants, the isolation between channels and the deferral of a write made in mid-period are visible only over whole periods. Only the bench scenarios show them, by tallying outputs against computed expectations.

// File: rtl/pwm_spread_pkg.sv
package pwm_spread_pkg;

    // Live shaping mode of one channel; also the state of its mode machine.
    typedef enum logic {
        MODE_CONT   = 1'b0,
        MODE_SPREAD = 1'b1
    } pwm_mode_e;

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Period boundary: the step that takes the counter back to zero.
    assign wrap = tick && (cnt == CMAX);
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_spread_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CW-1:0] wr_width,
    input  pwm_mode_e     wr_mode,
    input  logic          wrap,
    output logic [CW-1:0] act_width,
    output pwm_mode_e     act_mode
);
    logic [CW-1:0] pend_width;
    pwm_mode_e     pend_mode;
    pwm_mode_e     mode_nxt;

    // Pending slot: written at any time.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_width <= '0;
            pend_mode  <= MODE_CONT;
        end else if (we) begin
            pend_width <= wr_width;
            pend_mode  <= wr_mode;
        end
    end

    // Mode machine: only the period wrap may move it.
    always_comb begin
        mode_nxt = act_mode;
        unique case (act_mode)
            MODE_CONT:   if (wrap && pend_mode == MODE_SPREAD) mode_nxt = MODE_SPREAD;
            MODE_SPREAD: if (wrap && pend_mode == MODE_CONT)   mode_nxt = MODE_CONT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode  <= MODE_CONT;
            act_width <= '0;
        end else begin
            act_mode <= mode_nxt;
            if (wrap) act_width <= pend_width;
        end
    end
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out
    import pwm_spread_pkg::*;
#(
    parameter int CW = 10,
    parameter int QB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] width,
    input  pwm_mode_e     mode,
    output logic          pwm
);
    localparam int SEG = CW - QB;   // offset bits inside one quadrant

    logic [QB-1:0]  quad;
    logic [SEG-1:0] offs;
    logic [SEG-1:0] base;
    logic [QB-1:0]  extra;
    logic [SEG:0]   qlen;
    logic           hi_d;

    assign quad  = cnt[CW-1:SEG];
    assign offs  = cnt[SEG-1:0];
    assign base  = width[CW-1:QB];
    assign extra = width[QB-1:0];
    // Leading quadrants up to the low-bit value take one extra count.
    assign qlen  = {1'b0, base} + {{SEG{1'b0}}, (quad <= extra)};

    always_comb begin
        hi_d = 1'b0;
        unique case (mode)
            MODE_CONT:   hi_d = (cnt <= width);
            MODE_SPREAD: hi_d = ({1'b0, offs} < qlen);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= hi_d;
    end
endmodule

// File: rtl/pwm_spread4.sv
module pwm_spread4
    import pwm_spread_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 10,
    parameter int QB  = 2,
    parameter int SW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           wr_en,
    input  logic [SW-1:0]  wr_sel,
    input  logic [CW-1:0]  wr_width,
    input  logic           wr_spread,
    output logic [NCH-1:0] pwm_out
);
    logic [CW-1:0]           cnt_q;
    logic                    wrap;
    logic [NCH-1:0][CW-1:0]  act_w;
    logic [NCH-1:0]          act_sp;
    pwm_mode_e               wr_mode;

    assign wr_mode = wr_spread ? MODE_SPREAD : MODE_CONT;

    pwm_counter #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cnt  (cnt_q),
        .wrap (wrap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic      ch_we;
        pwm_mode_e ch_mode;

        assign ch_we     = wr_en && (wr_sel == SW'(c));
        assign act_sp[c] = (ch_mode == MODE_SPREAD);

        pwm_chan_regs #(.CW(CW)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .we        (ch_we),
            .wr_width  (wr_width),
            .wr_mode   (wr_mode),
            .wrap      (wrap),
            .act_width (act_w[c]),
            .act_mode  (ch_mode)
        );

        pwm_chan_out #(.CW(CW), .QB(QB)) u_out (
            .clk   (clk),
            .rst   (rst),
            .cnt   (cnt_q),
            .width (act_w[c]),
            .mode  (ch_mode),
            .pwm   (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_spread4_chk.sv
module pwm_spread4_chk #(
    parameter int NCH = 4,
    parameter int CW  = 10
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic [CW-1:0]          cnt,
    input logic [NCH-1:0][CW-1:0] act_w,
    input logic [NCH-1:0]         act_sp,
    input logic [NCH-1:0]         pwm_out
);
    localparam logic [CW-1:0] CMAX = '1;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst) (tick && cnt == CMAX) |=> (cnt == '0)) else $error("counter did not wrap"); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) (tick && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1)) else $error("counter did not step"); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(cnt)) else $error("counter moved without tick"); // R5
    AST_LIVE_STABLE: assert property (@(posedge clk) disable iff (rst) !(tick && cnt == CMAX) |=> ($stable(act_w) && $stable(act_sp))) else $error("live settings changed off wrap"); // R7
    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst) (cnt == '0) |=> (&pwm_out)) else $error("output low at period start"); // R3
    AST_RESET_LOW: assert property (@(posedge clk) rst |=> (pwm_out == '0)) else $error("output not cleared by reset"); // R9

    for (genvar c = 0; c < NCH; c++) begin : g_full
        AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst) (act_w[c] == CMAX && !act_sp[c]) |=> pwm_out[c]) else $error("full width not high"); // R2
    end
endmodule

bind pwm_spread4 pwm_spread4_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (cnt_q),
    .act_w   (act_w),
    .act_sp  (act_sp),
    .pwm_out (pwm_out)
);

// File: tb/sim_pwm_spread4.sv
`timescale 1ns/1ps
module sim_pwm_spread4;
    localparam int NCH = 4;
    localparam int PER = 1024;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_sel = '0;
    logic [9:0]     wr_width = '0;
    logic           wr_spread = 1'b0;
    logic [NCH-1:0] pwm_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  cmp_en = 0;

    always #2.5 clk = ~clk;

    pwm_spread4 u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_width(wr_width), .wr_spread(wr_spread), .pwm_out(pwm_out)
    );

    // Expected level per R2/R3 for count k, width n, mode sp.
    function automatic bit exp_hi(int k, int n, bit sp);
        int q, off, len;
        if (!sp) return k <= n;
        q   = k / 256;
        off = k % 256;
        len = n / 4 + ((q <= n % 4) ? 1 : 0);
        return off < len;
    endfunction

    // Bench model of the requirements
    int             m_cnt, m_pc;
    int             m_pw[NCH], m_aw[NCH];
    bit             m_ps[NCH], m_as[NCH];
    logic [NCH-1:0] m_out;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_pc <= 0; m_out <= '0;
            for (int c = 0; c < NCH; c++) begin
                m_pw[c] <= 0; m_aw[c] <= 0; m_ps[c] <= 0; m_as[c] <= 0;
            end
        end else begin
            m_pc <= m_cnt;
            for (int c = 0; c < NCH; c++) m_out[c] <= exp_hi(m_cnt, m_aw[c], m_as[c]);
            if (wr_en) begin
                m_pw[wr_sel] <= int'(wr_width);
                m_ps[wr_sel] <= wr_spread;
            end
            if (tick) begin
                m_cnt <= (m_cnt + 1) % PER;
                if (m_cnt == PER - 1)
                    for (int c = 0; c < NCH; c++) begin
                        m_aw[c] <= m_pw[c]; m_as[c] <= m_ps[c];
                    end
            end
        end
    end

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R8: per-cycle comparison with the registered model
    always @(negedge clk) begin
        if (cmp_en && !rst)
            for (int c = 0; c < NCH; c++)
                check_eq($sformatf("R8 ch%0d count %0d", c, m_pc), int'(pwm_out[c]), int'(m_out[c]));
    end

    task automatic wr(int ch, int w, bit sp);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(ch); wr_width = 10'(w); wr_spread = sp;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    int hi[NCH];
    int qh[NCH][4];

    task automatic tally();
        for (int c = 0; c < NCH; c++) begin
            hi[c] = 0;
            for (int q = 0; q < 4; q++) qh[c][q] = 0;
        end
        tick = 1'b1;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++)
                if (pwm_out[c]) begin
                    hi[c]++;
                    qh[c][m_pc / 256]++;
                end
        end
    endtask

    task automatic run_pair(int a, int b);
        wr(0, a, 0); wr(1, a, 1); wr(2, b, 0); wr(3, b, 1);
        tick = 1'b1;
        repeat (2 * PER + 4) @(negedge clk);
        tally();
        check_eq($sformatf("R2 cont total n=%0d", a), hi[0], a + 1);
        check_eq($sformatf("R4 spread total n=%0d", a), hi[1], a + 1);
        check_eq($sformatf("R6 ch2 total n=%0d", b), hi[2], b + 1);
        check_eq($sformatf("R6 ch3 total n=%0d", b), hi[3], b + 1);
        for (int q = 0; q < 4; q++) begin
            check_eq($sformatf("R3 q%0d n=%0d", q, a), qh[1][q], a / 4 + ((q <= a % 4) ? 1 : 0));
            check_eq($sformatf("R3 q%0d n=%0d", q, b), qh[3][q], b / 4 + ((q <= b % 4) ? 1 : 0));
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int lows, changes, gap, t0;
        logic [NCH-1:0] held;
        void'($urandom(32'd20250));

        repeat (3) @(negedge clk);
        check_eq("R9 outputs during reset", int'(pwm_out), 0);
        rst = 1'b0;
        cmp_en = 1;

        // R9: cleared widths give one high count per period
        tally();
        for (int c = 0; c < NCH; c++) check_eq($sformatf("R9 ch%0d after reset", c), hi[c], 1);

        // R1: distance between rising edges with a steady tick
        wr(0, 5, 0);
        tick = 1'b1;
        repeat (2 * PER + 4) @(negedge clk);
        t0 = 0;
        while (!(pwm_out[0] == 1'b1 && m_pc == 0) && t0 < 3 * PER) begin @(negedge clk); t0++; end
        gap = 0;
        do begin @(negedge clk); gap++; end while (!(pwm_out[0] == 1'b1 && m_pc == 0) && gap < 3 * PER);
        check_eq("R1 period length", gap, PER);

        run_pair(0, 1023);
        run_pair(1, 2);
        run_pair(3, 4);
        run_pair(511, 766);
        run_pair(1022, 5);
        for (int r = 0; r < 2; r++) run_pair(int'($urandom % PER), int'($urandom % PER));

        // R7: a mid-period write must not cut the current period short
        wr(0, 1023, 0);
        repeat (2 * PER + 4) @(negedge clk);
        while (m_pc != 600) @(negedge clk);
        wr(0, 0, 0);
        lows = 0;
        do begin @(negedge clk); if (!pwm_out[0]) lows++; end while (m_pc != PER - 1);
        check_eq("R7 old width kept until wrap", lows, 0);
        while (m_pc != 5) @(negedge clk);
        check_eq("R7 new width after wrap", int'(pwm_out[0]), 0);

        // R5: no tick, no change
        run_pair(300, 77);
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        held = pwm_out;
        changes = 0;
        repeat (40) begin @(negedge clk); if (pwm_out != held) changes++; end
        check_eq("R5 outputs held without tick", changes, 0);

        // R9: reset in mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R9 outputs during mid-run reset", int'(pwm_out), 0);
        rst = 1'b0;
        tally();
        for (int c = 0; c < NCH; c++) check_eq($sformatf("R9 ch%0d after mid-run reset", c), hi[c], 1);

        // Random ticks and writes, checked cycle by cycle (R6, R7, R8)
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            tick      = ($urandom % 4) != 0;
            wr_en     = ($urandom % 40) == 0;
            wr_sel    = 2'($urandom % 4);
            wr_width  = 10'($urandom % PER);
            wr_spread = 1'($urandom % 2);
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end
endmodule